// File: doc/BRIEF.md
# Synchronizer Mode Control FSM

This block decides how a telecom clock synchronizer runs. It picks one of three operating modes: Normal, where the PLL tracks a reference; Holdover, where the PLL keeps the last good frequency; and Freerun, where the PLL runs from its master clock alone. It also picks which of two references, primary or secondary, feeds the PLL. The block drives the reference multiplexer select, the PLL state lines and an enable for the phase (TIE) corrector. The PLL, the corrector arithmetic and the output dividers are outside this block.

All control inputs pass through a flop synchronizer before the block uses them. The 8 kHz frame pulse goes through the same synchronizer. The block changes state only on the rising edge of that synchronized pulse. Between edges, the outputs hold steady whatever the control pins do.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the block is in Freerun (`pll_state_o` = 2'b10) with the primary reference selected (`ref_mux_sel_o` = 0) and `tie_en_o` = 0.
- R2: The outputs change only on a rising edge of the synchronized frame pulse. Changes on the control inputs between edges have no effect on the outputs.
- R3: On each frame edge, `ref_mux_sel_o` takes the value of `ref_sel_i`: 0 selects the primary reference and 1 selects the secondary reference.
- R4: With `mode_sel_i` = 2'b00 (automatic) and `impaired_i` = 0, a frame edge moves the block to Normal (`pll_state_o` = 2'b00).
- R5: With `mode_sel_i` = 2'b00, a frame edge in Normal while `impaired_i` = 1 moves the block to Holdover (`pll_state_o` = 2'b01). A later frame edge with `impaired_i` = 0 returns it to Normal.
- R6: With `mode_sel_i` = 2'b01, a frame edge moves the block to Holdover, whatever the state of `impaired_i`.
- R7: With `mode_sel_i` = 2'b10, a frame edge moves the block to Freerun. The code 2'b11 is reserved and behaves the same as 2'b10.
- R8: Consider a frame edge that moves the block from primary Holdover to primary Normal. If `phase_corr_i` = 1 on that edge, `tie_en_o` goes to 1 for exactly one frame and returns to 0 on the next frame edge. If `phase_corr_i` = 0, `tie_en_o` stays 0.
- R9: `tie_en_o` stays 0 on every other move into Normal. This covers Freerun to Normal, secondary Holdover to Normal, and Holdover to Normal when the reference changes on the same edge.
- R10: With `mode_sel_i` = 2'b00 and `impaired_i` = 1, a frame edge in Freerun leaves the block in Freerun, because it has no history to hold over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse_i | input | 1 | 8 kHz frame pulse; its rising edge qualifies state updates |
| mode_sel_i | input | 2 | Mode select: 00 auto, 01 holdover, 10 freerun, 11 freerun |
| ref_sel_i | input | 1 | Reference request: 0 primary, 1 secondary |
| phase_corr_i | input | 1 | Allows TIE correction on the primary holdover-to-normal move |
| impaired_i | input | 1 | Reference impairment flag from the input monitor |
| ref_mux_sel_o | output | 1 | Reference multiplexer select: 0 primary, 1 secondary |
| tie_en_o | output | 1 | One-frame TIE corrector enable |
| pll_state_o | output | 2 | PLL state: 00 normal, 01 holdover, 10 freerun |

## Verification
The assertions assume that every control input is held steady across the frame edge that samples it. This means the synchronized copies that the checker watches are the same values that the state update used. The bench keeps to this rule. It changes inputs only while the frame pulse is low and leaves several clocks before raising the pulse. It also holds the pulse high and then low for several clocks, so that each pulse produces exactly one synchronized edge.

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_pulse_i,
  input  logic [1:0] mode_sel_i,
  input  logic       ref_sel_i,
  input  logic       phase_corr_i,
  input  logic       impaired_i,
  output logic       ref_mux_sel_o,
  output logic       tie_en_o,
  output logic [1:0] pll_state_o
);
  localparam int NIN = 6;
  localparam logic [1:0] ST_NORMAL = 2'b00;
  localparam logic [1:0] ST_HOLD   = 2'b01;
  localparam logic [1:0] ST_FREE   = 2'b10;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic [NIN-1:0] synced;
  logic           fp_d;
  logic           tick;
  logic [1:0]     mode_s;
  logic           ref_s, pcc_s, imp_s;
  logic [1:0]     state_q, state_nx;
  logic           ref_q, tie_q, tie_nx;

  assign raw = {frame_pulse_i, impaired_i, phase_corr_i, ref_sel_i, mode_sel_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      fp_d <= 1'b0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      fp_d <= sync_q[SYNC_STAGES-1][5];
    end
  end

  assign synced = sync_q[SYNC_STAGES-1];
  assign mode_s = synced[1:0];
  assign ref_s  = synced[2];
  assign pcc_s  = synced[3];
  assign imp_s  = synced[4];
  assign tick   = synced[5] & ~fp_d;

  always_comb begin
    unique case (mode_s)
      2'b00:   state_nx = imp_s ? ((state_q == ST_FREE) ? ST_FREE : ST_HOLD) : ST_NORMAL;
      2'b01:   state_nx = ST_HOLD;
      default: state_nx = ST_FREE;
    endcase
  end

  assign tie_nx = (state_q == ST_HOLD) && !ref_q && (state_nx == ST_NORMAL) && !ref_s && pcc_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FREE;
      ref_q   <= 1'b0;
      tie_q   <= 1'b0;
    end else if (tick) begin
      state_q <= state_nx;
      ref_q   <= ref_s;
      tie_q   <= tie_nx;
    end
  end

  assign pll_state_o   = state_q;
  assign ref_mux_sel_o = ref_q;
  assign tie_en_o      = tie_q;
endmodule

// File: rtl/sync_mode_ctrl_chk.sv
module sync_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [1:0] mode_s,
  input logic       ref_s,
  input logic       ref_mux_sel_o,
  input logic       tie_en_o,
  input logic [1:0] pll_state_o
);
  p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pll_state_o != 2'b11);

  p_stable_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pll_state_o) && $stable(ref_mux_sel_o) && $stable(tie_en_o)));

  p_ref_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ref_mux_sel_o == $past(ref_s));

  p_forced_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_s == 2'b01) |=> pll_state_o == 2'b01);

  p_forced_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_s[1]) |=> pll_state_o == 2'b10);

  p_tie_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tie_en_o) |-> (pll_state_o == 2'b00 && !ref_mux_sel_o &&
                         $past(pll_state_o) == 2'b01 && !$past(ref_mux_sel_o)));

  p_tie_in_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tie_en_o |-> (pll_state_o == 2'b00 && !ref_mux_sel_o));
endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode_s(mode_s), .ref_s(ref_s),
  .ref_mux_sel_o(ref_mux_sel_o), .tie_en_o(tie_en_o), .pll_state_o(pll_state_o)
);

// File: tb/tb_sync_mode_ctrl.sv
`timescale 1ns/1ps
module tb_sync_mode_ctrl;
  logic clk = 0, rst_n = 0;
  logic fp = 0, ref_sel = 0, pcc = 0, imp = 0;
  logic [1:0] mode = 2'b10;
  logic ref_o, tie_o;
  logic [1:0] st_o;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sync_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .frame_pulse_i(fp), .mode_sel_i(mode),
    .ref_sel_i(ref_sel), .phase_corr_i(pcc), .impaired_i(imp),
    .ref_mux_sel_o(ref_o), .tie_en_o(tie_o), .pll_state_o(st_o)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_out(string req, logic [1:0] st, logic rf, logic te);
    check({req, " state"}, {2'b0, st_o}, {2'b0, st});
    check({req, " ref"},   {3'b0, ref_o}, {3'b0, rf});
    check({req, " tie"},   {3'b0, tie_o}, {3'b0, te});
  endtask

  task automatic frame();
    repeat (4) @(negedge clk);
    fp = 1;
    repeat (5) @(negedge clk);
    fp = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic set(logic [1:0] m, logic r, logic p, logic i);
    @(negedge clk);
    mode = m; ref_sel = r; pcc = p; imp = i;
  endtask

  task automatic t_reset();
    expect_out("R1 in reset", 2'b10, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);
    expect_out("R1 after reset", 2'b10, 1'b0, 1'b0);
  endtask

  task automatic t_normal_and_hold_off();
    set(2'b00, 0, 1, 0); frame();
    expect_out("R4 R9 freerun to normal", 2'b00, 1'b0, 1'b0);
    set(2'b10, 1, 1, 1);
    repeat (20) @(negedge clk);
    expect_out("R2 no frame edge", 2'b00, 1'b0, 1'b0);
  endtask

  task automatic t_auto_holdover();
    set(2'b00, 0, 1, 1); frame();
    expect_out("R5 impaired to holdover", 2'b01, 1'b0, 1'b0);
    set(2'b00, 0, 1, 0); frame();
    expect_out("R5 R8 back to normal with TIE", 2'b00, 1'b0, 1'b1);
    frame();
    expect_out("R8 TIE lasts one frame", 2'b00, 1'b0, 1'b0);
  endtask

  task automatic t_pcc_off();
    set(2'b01, 0, 0, 0); frame();
    expect_out("R6 forced holdover", 2'b01, 1'b0, 1'b0);
    set(2'b00, 0, 0, 0); frame();
    expect_out("R8 pcc off no TIE", 2'b00, 1'b0, 1'b0);
  endtask

  task automatic t_secondary();
    set(2'b01, 1, 1, 0); frame();
    expect_out("R3 R6 secondary holdover", 2'b01, 1'b1, 1'b0);
    set(2'b00, 1, 1, 0); frame();
    expect_out("R9 secondary to normal no TIE", 2'b00, 1'b1, 1'b0);
    set(2'b01, 0, 1, 1); frame();
    expect_out("R3 R6 primary holdover while impaired", 2'b01, 1'b0, 1'b0);
    set(2'b00, 1, 1, 0); frame();
    expect_out("R9 ref change on exit no TIE", 2'b00, 1'b1, 1'b0);
  endtask

  task automatic t_freerun();
    set(2'b10, 0, 1, 0); frame();
    expect_out("R7 forced freerun", 2'b10, 1'b0, 1'b0);
    set(2'b00, 1, 1, 0); frame();
    set(2'b11, 1, 1, 0); frame();
    expect_out("R7 reserved code is freerun", 2'b10, 1'b1, 1'b0);
    set(2'b00, 0, 1, 1); frame();
    expect_out("R10 freerun stays on impairment", 2'b10, 1'b0, 1'b0);
    set(2'b00, 0, 1, 0); frame();
    expect_out("R9 freerun to normal no TIE", 2'b00, 1'b0, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_normal_and_hold_off();
        t_auto_holdover();
        t_pcc_off();
        t_secondary();
        t_freerun();
      end
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule